// File: doc/BRIEF.md
# Four-Port Stream Packet Switch

This block connects four stream sources to four stream sinks. Each frame that arrives on an input is steered to one output, chosen by the frame's destination field. Each output claims an inclusive window of destination values, set by a pair of parameters. A per-output parameter mask lists which inputs may reach that output. Data, byte enables, ID, destination, user and end-of-frame markers all travel with the frame.

The first beat of a frame fixes its route. From then on the input is tied to its output until the beat carrying the end-of-frame marker has been handed over. When several idle inputs want the same free output, a round-robin arbiter chooses one, so frames on an output never mix. A frame with no legal route is still accepted, beat by beat, and then discarded, so it cannot hold up traffic on other inputs. Every output has one register stage that keeps its beat steady while the sink stalls.

Top module: `stream_xbar`

## Requirements
- R1: A frame whose destination d lies in output n's inclusive window [BASE slice n, TOP slice n] is delivered to output n. By default output n's window is exactly n. The slice for output n sits at bits [n*DSTW +: DSTW] of BASE and of TOP. A source must keep the destination field constant for the whole frame.
- R2: When the windows of several outputs contain d, the frame goes only to the lowest-numbered output among them.
- R3: When the lowest-numbered output whose window contains d has its mask bit for the sending input clear, the frame is accepted and dropped. Bit i of CONNECT slice n, at bit n*NI+i, permits input i to reach output n. The default mask is all ones.
- R4: When no window contains d (by default, d = 4 to 7), the frame is accepted and dropped, and no output shows any of its beats. Such a frame is consumed at one beat per cycle after a single decode cycle, regardless of the other inputs.
- R5: Once an output has started a frame from one input, it carries no beat from any other input until that frame's end-of-frame beat has been accepted.
- R6: Among idle inputs requesting the same free output, the arbiter searches from a rotating pointer, and the first requester it meets is granted. After reset the pointer is 0, so the lowest index wins. After a grant to input k, the search starts at k+1. Four simultaneous frames to one output after reset therefore leave in input order 0, 1, 2, 3. If input 0 sends two frames and input 1 sends one, the output order is 0, 1, 0.
- R7: The byte enables, ID, destination, user bit and end-of-frame marker of every beat appear on the output unchanged, together with that beat's data.
- R8: While an output's valid is high and its ready is low, its valid and all of its payload stay unchanged. Sources that insert idle cycles and sinks that stall lose no beats and duplicate none.
- R9: Reset is synchronous and active high. In the first cycle after reset, every output valid and every input ready is low. An input's ready stays low in the cycle in which the first beat of a frame first appears (the decode cycle). It rises in the next cycle if that input's route is granted.
- R10: Back-to-back frames from one input with different destinations each reach their own output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_data | input | NI*DW | Input data, input i at [i*DW +: DW] |
| s_keep | input | NI*DW/8 | Input byte enables |
| s_valid | input | NI | Input beat valid |
| s_ready | output | NI | Input beat accepted |
| s_last | input | NI | Input end-of-frame |
| s_id | input | NI*IW | Input stream ID |
| s_dest | input | NI*DSTW | Input destination |
| s_user | input | NI*UW | Input user sideband |
| m_data | output | NO*DW | Output data, output n at [n*DW +: DW] |
| m_keep | output | NO*DW/8 | Output byte enables |
| m_valid | output | NO | Output beat valid |
| m_ready | input | NO | Output sink ready |
| m_last | output | NO | Output end-of-frame |
| m_id | output | NO*IW | Output stream ID |
| m_dest | output | NO*DSTW | Output destination |
| m_user | output | NO*UW | Output user sideband |

## Verification
The bench is built with overlapping windows and with one cleared mask bit, so each corner case has a clear right answer. A priority decoder with the wrong direction would send destination 2 to output 3. A mask that is ignored would leak the blocked frame onto output 1. The bench checks both. The bench also sends four contending frames and a 0-1-0 sequence to one output. A grant released before the end-of-frame beat would interleave beats, and a pointer that does not rotate would deliver the second frame of input 0 ahead of the frame from input 1. Drop frames are run beside live traffic, and sinks are throttled while sources insert gaps. A design that stalls on drops, leaks dropped beats, or loses payload under backpressure would show up as missing, extra or corrupted beats.

// File: rtl/stream_xbar.sv
module stream_xbar #(
  parameter int NI   = 4,
  parameter int NO   = 4,
  parameter int DW   = 64,
  parameter int IW   = 8,
  parameter int DSTW = 3,
  parameter int UW   = 1,
  parameter logic [NO*DSTW-1:0] BASE    = {3'd3, 3'd2, 3'd1, 3'd0},
  parameter logic [NO*DSTW-1:0] TOP     = {3'd3, 3'd2, 3'd1, 3'd0},
  parameter logic [NO*NI-1:0]   CONNECT = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NI*DW-1:0]   s_data,
  input  logic [NI*DW/8-1:0] s_keep,
  input  logic [NI-1:0]      s_valid,
  output logic [NI-1:0]      s_ready,
  input  logic [NI-1:0]      s_last,
  input  logic [NI*IW-1:0]   s_id,
  input  logic [NI*DSTW-1:0] s_dest,
  input  logic [NI*UW-1:0]   s_user,
  output logic [NO*DW-1:0]   m_data,
  output logic [NO*DW/8-1:0] m_keep,
  output logic [NO-1:0]      m_valid,
  input  logic [NO-1:0]      m_ready,
  output logic [NO-1:0]      m_last,
  output logic [NO*IW-1:0]   m_id,
  output logic [NO*DSTW-1:0] m_dest,
  output logic [NO*UW-1:0]   m_user
);
  localparam int KW = DW / 8;
  localparam int SW = (NI > 1) ? $clog2(NI) : 1;
  localparam int OW = (NO > 1) ? $clog2(NO) : 1;

  logic [NI-1:0] act, drop, hit, ok, fire, done;
  logic [OW-1:0] sel  [NI];
  logic [OW-1:0] dsel [NI];
  logic [NO-1:0] busy, win, acc, ld;
  logic [SW-1:0] gnt [NO];
  logic [SW-1:0] ptr [NO];
  logic [SW-1:0] pk  [NO];

  always_comb begin
    for (int i = 0; i < NI; i++) begin
      hit[i]  = 1'b0;
      dsel[i] = '0;
      for (int o = NO - 1; o >= 0; o--) begin
        if (s_dest[i*DSTW +: DSTW] >= BASE[o*DSTW +: DSTW] &&
            s_dest[i*DSTW +: DSTW] <= TOP[o*DSTW +: DSTW]) begin
          hit[i]  = 1'b1;
          dsel[i] = OW'(o);
        end
      end
      ok[i] = hit[i] && CONNECT[int'(dsel[i])*NI + i];
    end
  end

  always_comb begin
    for (int o = 0; o < NO; o++) begin
      logic found;
      int   idx;
      found = 1'b0;
      pk[o] = '0;
      for (int k = 0; k < NI; k++) begin
        idx = (int'(ptr[o]) + k) % NI;
        if (!found && !act[idx] && s_valid[idx] && ok[idx] && dsel[idx] == OW'(o)) begin
          found = 1'b1;
          pk[o] = SW'(idx);
        end
      end
      win[o] = found && !busy[o];
    end
  end

  assign acc = ~m_valid | m_ready;

  always_comb begin
    for (int i = 0; i < NI; i++) begin
      s_ready[i] = act[i] && (drop[i] || acc[sel[i]]);
      fire[i]    = s_valid[i] && s_ready[i];
      done[i]    = fire[i] && s_last[i];
    end
    for (int o = 0; o < NO; o++)
      ld[o] = busy[o] && fire[gnt[o]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act     <= '0;
      drop    <= '0;
      busy    <= '0;
      m_valid <= '0;
      for (int o = 0; o < NO; o++) ptr[o] <= '0;
    end else begin
      for (int i = 0; i < NI; i++) begin
        if (done[i]) begin
          act[i] <= 1'b0;
        end else if (!act[i] && s_valid[i] && !ok[i]) begin
          act[i]  <= 1'b1;
          drop[i] <= 1'b1;
        end
      end
      for (int o = 0; o < NO; o++) begin
        if (win[o]) begin
          busy[o]       <= 1'b1;
          gnt[o]        <= pk[o];
          ptr[o]        <= (int'(pk[o]) == NI - 1) ? '0 : pk[o] + 1'b1;
          act[pk[o]]    <= 1'b1;
          drop[pk[o]]   <= 1'b0;
          sel[pk[o]]    <= OW'(o);
        end else if (busy[o] && done[gnt[o]]) begin
          busy[o] <= 1'b0;
        end
        if (ld[o])
          m_valid[o] <= 1'b1;
        else if (m_ready[o])
          m_valid[o] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int o = 0; o < NO; o++) begin
      if (ld[o]) begin
        m_data[o*DW +: DW]     <= s_data[int'(gnt[o])*DW +: DW];
        m_keep[o*KW +: KW]     <= s_keep[int'(gnt[o])*KW +: KW];
        m_last[o]              <= s_last[gnt[o]];
        m_id[o*IW +: IW]       <= s_id[int'(gnt[o])*IW +: IW];
        m_dest[o*DSTW +: DSTW] <= s_dest[int'(gnt[o])*DSTW +: DSTW];
        m_user[o*UW +: UW]     <= s_user[int'(gnt[o])*UW +: UW];
      end
    end
  end
endmodule

// File: rtl/stream_xbar_chk.sv
module stream_xbar_chk #(
  parameter int NI   = 4,
  parameter int NO   = 4,
  parameter int DW   = 64,
  parameter int DSTW = 3,
  parameter logic [NO*DSTW-1:0] BASE    = '0,
  parameter logic [NO*DSTW-1:0] TOP     = '0,
  parameter logic [NO*NI-1:0]   CONNECT = '1,
  parameter int SW = 2,
  parameter int OW = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [NI-1:0]      s_valid,
  input logic [NI-1:0]      s_ready,
  input logic [NI-1:0]      s_last,
  input logic [NO-1:0]      m_valid,
  input logic [NO-1:0]      m_ready,
  input logic [NO*DW-1:0]   m_data,
  input logic [NO-1:0]      m_last,
  input logic [NO*DSTW-1:0] m_dest,
  input logic [NO-1:0]      busy,
  input logic [SW-1:0]      gnt [NO],
  input logic [NI-1:0]      act,
  input logic [NI-1:0]      drop,
  input logic [OW-1:0]      sel [NI]
);
  logic [NI-1:0] own [NO];
  always_comb
    for (int o = 0; o < NO; o++)
      for (int i = 0; i < NI; i++)
        own[o][i] = act[i] && !drop[i] && sel[i] == OW'(o);

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (m_valid == '0 && s_ready == '0));

  for (genvar o = 0; o < NO; o++) begin : g_out
    // R8
    hold_payload_chk: assert property (@(posedge clk) disable iff (rst)
      (m_valid[o] && !m_ready[o]) |=> (m_valid[o] && $stable(m_data[o*DW +: DW]) &&
        $stable(m_last[o]) && $stable(m_dest[o*DSTW +: DSTW])));
    // R1
    dest_window_chk: assert property (@(posedge clk) disable iff (rst)
      m_valid[o] |-> (m_dest[o*DSTW +: DSTW] >= BASE[o*DSTW +: DSTW] &&
                      m_dest[o*DSTW +: DSTW] <= TOP[o*DSTW +: DSTW]));
    // R5
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (busy[o] && !(s_valid[gnt[o]] && s_ready[gnt[o]] && s_last[gnt[o]])) |=>
        (busy[o] && $stable(gnt[o])));
    // R3
    connect_chk: assert property (@(posedge clk) disable iff (rst)
      busy[o] |-> CONNECT[o*NI + int'(gnt[o])]);
    // R6
    single_owner_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(own[o]));
  end
endmodule

bind stream_xbar stream_xbar_chk #(
  .NI(NI), .NO(NO), .DW(DW), .DSTW(DSTW), .BASE(BASE), .TOP(TOP),
  .CONNECT(CONNECT), .SW(SW), .OW(OW)
) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_last(s_last),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
  .m_dest(m_dest), .busy(busy), .gnt(gnt), .act(act), .drop(drop), .sel(sel)
);

// File: tb/sim_stream_xbar.sv
`timescale 1ns/1ps
module sim_stream_xbar;
  typedef struct packed {
    logic [1:0]  port;
    logic [63:0] d;
    logic [7:0]  k;
    logic [7:0]  id;
    logic [2:0]  dst;
    logic        u;
    logic        l;
  } rec_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [63:0] sd [4];
  logic [7:0]  sk [4];
  logic [7:0]  sid [4];
  logic [2:0]  sdst [4];
  logic        su [4];
  logic [3:0]  sv = '0, sl = '0, mr = '1;
  logic        stall = 1'b0;
  int          cyc = 0;

  logic [255:0] s_data;
  logic [31:0]  s_keep, s_id;
  logic [11:0]  s_dest;
  logic [3:0]   s_user, s_ready;
  logic [255:0] m_data;
  logic [31:0]  m_keep, m_id;
  logic [11:0]  m_dest;
  logic [3:0]   m_user, m_valid, m_last;

  always_comb
    for (int i = 0; i < 4; i++) begin
      s_data[i*64 +: 64] = sd[i];
      s_keep[i*8 +: 8]   = sk[i];
      s_id[i*8 +: 8]     = sid[i];
      s_dest[i*3 +: 3]   = sdst[i];
      s_user[i]          = su[i];
    end

  stream_xbar #(
    .BASE({3'd2, 3'd2, 3'd1, 3'd0}),
    .TOP({3'd3, 3'd2, 3'd1, 3'd0}),
    .CONNECT({4'hF, 4'hF, 4'hD, 4'hF})
  ) u0 (
    .clk(clk), .rst(rst),
    .s_data(s_data), .s_keep(s_keep), .s_valid(sv), .s_ready(s_ready), .s_last(sl),
    .s_id(s_id), .s_dest(s_dest), .s_user(s_user),
    .m_data(m_data), .m_keep(m_keep), .m_valid(m_valid), .m_ready(mr), .m_last(m_last),
    .m_id(m_id), .m_dest(m_dest), .m_user(m_user)
  );

  int total = 0, bad = 0;
  rec_t got[$], exp_q[$];

  initial forever begin
    @(posedge clk);
    cyc++;
    #1;
    for (int o = 0; o < 4; o++) mr[o] = !stall || ((cyc + o) % 3 == 0);
  end

  initial forever begin
    @(negedge clk);
    for (int o = 0; o < 4; o++)
      if (m_valid[o] && mr[o])
        got.push_back('{2'(o), m_data[o*64 +: 64], m_keep[o*8 +: 8], m_id[o*8 +: 8],
                        m_dest[o*3 +: 3], m_user[o], m_last[o]});
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string r, input longint act, input longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, expv);
    end
  endtask

  function automatic rec_t mk(int o, int dst, int tag, int b, int nb);
    rec_t x;
    x.port = 2'(o);
    x.d    = {32'(tag), 32'(b)};
    x.k    = (b == nb - 1) ? 8'h0F : 8'hFF;
    x.id   = 8'(tag);
    x.dst  = 3'(dst);
    x.u    = b[0];
    x.l    = (b == nb - 1);
    return x;
  endfunction

  task automatic expect_frame(int o, int dst, int tag, int nb);
    for (int b = 0; b < nb; b++) exp_q.push_back(mk(o, dst, tag, b, nb));
  endtask

  task automatic send(int i, int dst, int tag, int nb, int gap);
    for (int b = 0; b < nb; b++) begin
      rec_t x;
      x = mk(0, dst, tag, b, nb);
      sd[i] = x.d; sk[i] = x.k; sid[i] = x.id; sdst[i] = x.dst; su[i] = x.u; sl[i] = x.l;
      sv[i] = 1'b1;
      do @(negedge clk); while (!s_ready[i]);
      @(posedge clk);
      #1;
      sv[i] = 1'b0;
      for (int g = 0; g < gap; g++) begin
        @(posedge clk);
        #1;
      end
    end
  endtask

  task automatic compare(input string r);
    repeat (40) @(posedge clk);
    #1;
    for (int o = 0; o < 4; o++) begin
      rec_t a[$], e[$];
      foreach (got[n]) if (got[n].port == 2'(o)) a.push_back(got[n]);
      foreach (exp_q[n]) if (exp_q[n].port == 2'(o)) e.push_back(exp_q[n]);
      total++;
      if (a.size() != e.size()) begin
        bad++;
        $display("FAIL %s out%0d beat count: actual=%0d expected=%0d", r, o, a.size(), e.size());
      end else begin
        foreach (a[n])
          if (a[n] != e[n]) begin
            bad++;
            $display("FAIL %s out%0d beat %0d: actual=%h expected=%h", r, o, n, a[n], e[n]);
            break;
          end
      end
    end
    got.delete();
    exp_q.delete();
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 valid in reset", m_valid, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    sd[0] = {32'h10, 32'h0}; sk[0] = 8'h0F; sid[0] = 8'h10; sdst[0] = 3'd0; su[0] = 1'b0; sl[0] = 1'b1;
    sv[0] = 1'b1;
    @(negedge clk);
    chk("R9 ready in decode cycle", s_ready, 0);
    chk("R9 valid after reset", m_valid, 0);
    @(negedge clk);
    chk("R9 ready after grant", s_ready[0], 1);
    @(posedge clk); #1;
    sv[0] = 1'b0;
    expect_frame(0, 0, 16'h10, 1);
    compare("R9 first frame");
  endtask

  task automatic t_straight(int gap, bit st, string r);
    stall = st;
    expect_frame(0, 0, 32'h21, 3);
    expect_frame(3, 3, 32'h22, 3);
    expect_frame(2, 2, 32'h23, 3);
    expect_frame(1, 1, 32'h24, 3);
    fork
      send(0, 0, 32'h21, 3, gap);
      send(1, 3, 32'h22, 3, gap);
      send(2, 2, 32'h23, 3, gap);
      send(3, 1, 32'h24, 3, gap);
    join
    compare({r, " pass A"});
    expect_frame(3, 3, 32'h25, 2);
    expect_frame(0, 0, 32'h26, 2);
    expect_frame(1, 1, 32'h27, 2);
    expect_frame(2, 2, 32'h28, 2);
    fork
      send(0, 3, 32'h25, 2, gap);
      send(1, 0, 32'h26, 2, gap);
      send(2, 1, 32'h27, 2, gap);
      send(3, 2, 32'h28, 2, gap);
    join
    compare({r, " pass B"});
    stall = 1'b0;
  endtask

  task automatic t_overlap();
    expect_frame(2, 2, 32'h31, 2);
    expect_frame(3, 3, 32'h32, 2);
    fork
      send(0, 2, 32'h31, 2, 0);
      send(1, 3, 32'h32, 2, 0);
    join
    compare("R2 overlapping windows");
  endtask

  task automatic t_connect();
    expect_frame(1, 1, 32'h41, 3);
    fork
      send(0, 1, 32'h41, 3, 0);
      send(1, 1, 32'h42, 3, 0);
    join
    compare("R3 masked input dropped");
  endtask

  task automatic t_drop();
    int c0, c1;
    expect_frame(0, 0, 32'h51, 3);
    expect_frame(3, 3, 32'h52, 3);
    stall = 1'b1;
    fork
      send(0, 0, 32'h51, 3, 0);
      send(1, 3, 32'h52, 3, 0);
      begin
        c0 = cyc;
        send(2, 5, 32'h53, 4, 0);
        c1 = cyc;
      end
      send(3, 7, 32'h54, 2, 1);
    join
    stall = 1'b0;
    chk("R4 drop frame cycles within 8", (c1 - c0) <= 8, 1);
    compare("R4 unroutable dropped");
  endtask

  task automatic t_contend();
    do_reset();
    for (int i = 0; i < 4; i++) expect_frame(0, 0, 32'h60 + i, 3);
    fork
      send(0, 0, 32'h60, 3, 0);
      send(1, 0, 32'h61, 3, 0);
      send(2, 0, 32'h62, 3, 0);
      send(3, 0, 32'h63, 3, 0);
    join
    compare("R5 R6 four-way contention");
    do_reset();
    expect_frame(0, 0, 32'h71, 2);
    expect_frame(0, 0, 32'h72, 2);
    expect_frame(0, 0, 32'h73, 2);
    fork
      begin
        send(0, 0, 32'h71, 2, 0);
        send(0, 0, 32'h73, 2, 0);
      end
      send(1, 0, 32'h72, 2, 0);
    join
    compare("R6 rotating pointer 0-1-0");
  endtask

  task automatic t_multi();
    stall = 1'b1;
    expect_frame(0, 0, 32'h81, 2);
    expect_frame(3, 3, 32'h82, 2);
    expect_frame(2, 2, 32'h83, 2);
    expect_frame(1, 1, 32'h84, 2);
    send(0, 0, 32'h81, 2, 0);
    send(0, 3, 32'h82, 2, 0);
    send(0, 2, 32'h83, 2, 0);
    send(0, 1, 32'h84, 2, 0);
    stall = 1'b0;
    compare("R10 one input many outputs");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      sd[i] = '0; sk[i] = '0; sid[i] = '0; sdst[i] = '0; su[i] = '0;
    end
    repeat (4) @(posedge clk);
    t_reset();
    t_straight(0, 1'b0, "R1 R7 routing");
    t_straight(2, 1'b1, "R8 gaps and stalls");
    t_overlap();
    t_connect();
    t_drop();
    t_contend();
    t_multi();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule